// File: doc/BRIEF.md
# Timed Command Executor

This block pops timed commands from a command queue and runs each one with exact cycle timing. A command that changes parameters applies the offset snapshot that travels with it to the output path in one step: both offset paths change together and an update strobe is pulsed. The executor then counts the command's duration. When that count ends, it pops the next command at once, whatever the previous command was still doing.

There are four command kinds. An update command applies parameters. A play command applies parameters and also pulses a play/acquire strobe. A wait command only spends time. A sync wait blocks until every enabled executor in a barrier group has arrived, and only then starts its duration count. Durations are given in nanoseconds, and one clock cycle stands for 4 ns. If the queue is empty when a command is due, the executor sets a sticky underflow flag and halts. A duration that is illegal sets a separate sticky error flag.

Top module: `rt_cmd_exec`

## Requirements
- R1: After reset, both offsets are 0, the update and play strobes are 0, both error flags are 0, sync_wait is 0 and cmd_pop is 0.
- R2: While idle, a start pulse with cmd_valid high pops the head command in that same cycle. A command of duration D ns causes the next pop exactly D/4 cycles after its own pop.
- R3: An update command (cmd_op 0) with a legal duration drives its two offsets onto ofs0/ofs1 in the cycle after its pop. In that same cycle upd_strobe is high for one cycle.
- R4: A play command (cmd_op 1) behaves like an update command. In addition, play_strobe is high in the same single cycle as upd_strobe.
- R5: A wait command (cmd_op 2) leaves ofs0/ofs1 unchanged and raises neither strobe, even when its snapshot holds other offsets.
- R6: ofs0/ofs1 keep their last applied value in every cycle in which upd_strobe is low.
- R7: If cmd_valid is low when a command is due, underflow becomes 1 in the next cycle and stays 1. While it is set, no further pops occur, even if the queue refills. A clr_err pulse clears the flag and returns the executor to idle, where it waits for start.
- R8: A popped command whose duration is below 4 or is not a multiple of 4 is consumed. It applies no parameters, sets dur_err in the next cycle and halts the executor, with the same sticky and clear behaviour as R7.
- R9: A sync-wait command (cmd_op 3) applies no parameters. sync_wait is high from the cycle after its pop until the release cycle. The release cycle is the first cycle in which every enabled bit of peer_arrive is 1. The next pop comes D/4 cycles after the release cycle.
- R10: A bit of peer_arrive whose sync_enable bit is 0 is ignored by the barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one cycle = 4 ns of command time) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution from idle |
| clr_err | input | 1 | Clear sticky flags and leave the halted state |
| cmd_valid | input | 1 | Command queue holds at least one entry |
| cmd_op | input | 2 | Head command kind: 0 update, 1 play, 2 wait, 3 sync wait |
| cmd_dur | input | 16 | Head command duration in ns |
| cmd_ofs0 | input | 16 | Head command offset snapshot, path 0 (signed) |
| cmd_ofs1 | input | 16 | Head command offset snapshot, path 1 (signed) |
| cmd_pop | output | 1 | Consume the head command this cycle |
| peer_arrive | input | 4 | Barrier arrival lines of the group, own line included |
| sync_enable | input | 4 | Barrier membership mask |
| sync_wait | output | 1 | This executor is waiting at a barrier |
| ofs0 | output | 16 | Applied offset, path 0 (signed) |
| ofs1 | output | 16 | Applied offset, path 1 (signed) |
| upd_strobe | output | 1 | Parameters applied this cycle |
| play_strobe | output | 1 | Play/acquire started this cycle |
| underflow | output | 1 | Sticky queue-starvation flag |
| dur_err | output | 1 | Sticky illegal-duration flag |

## Verification
The bench runs the minimum duration of one cycle back to back with longer ones. A counter that is off by one would shift every following pop, and the cycle-by-cycle comparison catches that. Wait and sync-wait commands carry offsets that differ from the ones already applied, so a design that applied them would show a change on ofs0/ofs1. The bench refills the queue while the executor is halted, which exposes a design that goes on popping after an error. The barrier is exercised with arrivals on different cycles, with a member that is disabled and never arrives, and with the executor as the only enabled member. A wrong mask would either hang or release early, and a wrong count start would move the next pop.

// File: rtl/rt_exec_pkg.sv
package rt_exec_pkg;
  typedef enum logic [1:0] {
    OP_UPD  = 2'd0,
    OP_PLAY = 2'd1,
    OP_WAIT = 2'd2,
    OP_SYNC = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SYNC = 2'd2,
    ST_HALT = 2'd3
  } st_e;
endpackage

// File: rtl/rt_dur_check.sv
module rt_dur_check #(
  parameter int DUR_W  = 16,
  parameter int CYC_NS = 4
) (
  input  logic [DUR_W-1:0] dur_ns,
  output logic             legal,
  output logic [DUR_W-1:0] cycles
);
  localparam int SH = $clog2(CYC_NS);
  localparam logic [DUR_W-1:0] MIN_NS = DUR_W'(CYC_NS);

  always_comb begin
    legal  = (dur_ns >= MIN_NS) && (dur_ns[SH-1:0] == '0);
    cycles = dur_ns >> SH;
  end
endmodule

// File: rtl/rt_barrier.sv
module rt_barrier #(
  parameter int N = 4
) (
  input  logic [N-1:0] arrive,
  input  logic [N-1:0] enable,
  output logic         release_all
);
  logic [N-1:0] ready;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign ready[i] = arrive[i] | ~enable[i];
  end

  assign release_all = &ready;
endmodule

// File: rtl/rt_param_out.sv
module rt_param_out #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             apply,
  input  logic             is_play,
  input  logic [OFS_W-1:0] snap0,
  input  logic [OFS_W-1:0] snap1,
  output logic [OFS_W-1:0] ofs0,
  output logic [OFS_W-1:0] ofs1,
  output logic             upd_strobe,
  output logic             play_strobe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ofs0        <= '0;
      ofs1        <= '0;
      upd_strobe  <= 1'b0;
      play_strobe <= 1'b0;
    end else begin
      upd_strobe  <= apply;
      play_strobe <= apply & is_play;
      if (apply) begin
        ofs0 <= snap0;
        ofs1 <= snap1;
      end
    end
  end

  // R4
  play_with_upd_chk: assert property (@(posedge clk) disable iff (rst)
    play_strobe |-> upd_strobe);
endmodule

// File: rtl/rt_cmd_exec.sv
module rt_cmd_exec
  import rt_exec_pkg::*;
#(
  parameter int DUR_W  = 16,
  parameter int OFS_W  = 16,
  parameter int N_SYNC = 4,
  parameter int CYC_NS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              clr_err,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DUR_W-1:0]  cmd_dur,
  input  logic [OFS_W-1:0]  cmd_ofs0,
  input  logic [OFS_W-1:0]  cmd_ofs1,
  output logic              cmd_pop,
  input  logic [N_SYNC-1:0] peer_arrive,
  input  logic [N_SYNC-1:0] sync_enable,
  output logic              sync_wait,
  output logic [OFS_W-1:0]  ofs0,
  output logic [OFS_W-1:0]  ofs1,
  output logic              upd_strobe,
  output logic              play_strobe,
  output logic              underflow,
  output logic              dur_err
);
  st_e              state;
  logic [DUR_W-1:0] cnt;
  logic [DUR_W-1:0] sync_cnt;
  logic             dur_ok;
  logic [DUR_W-1:0] dur_cyc;
  logic             release_all;
  logic             due;
  logic             apply;
  op_e              op;

  assign op = op_e'(cmd_op);

  rt_dur_check #(.DUR_W(DUR_W), .CYC_NS(CYC_NS)) u_dur (
    .dur_ns(cmd_dur), .legal(dur_ok), .cycles(dur_cyc)
  );

  rt_barrier #(.N(N_SYNC)) u_bar (
    .arrive(peer_arrive), .enable(sync_enable), .release_all(release_all)
  );

  always_comb begin
    due     = ((state == ST_IDLE) && start) || ((state == ST_RUN) && (cnt == '0));
    cmd_pop = due && cmd_valid;
    apply   = cmd_pop && dur_ok && ((op == OP_UPD) || (op == OP_PLAY));
  end

  rt_param_out #(.OFS_W(OFS_W)) u_par (
    .clk(clk), .rst(rst), .apply(apply), .is_play(op == OP_PLAY),
    .snap0(cmd_ofs0), .snap1(cmd_ofs1),
    .ofs0(ofs0), .ofs1(ofs1), .upd_strobe(upd_strobe), .play_strobe(play_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sync_cnt  <= '0;
      underflow <= 1'b0;
      dur_err   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_RUN: begin
          if ((state == ST_RUN) && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
          end else if (due) begin
            if (!cmd_valid) begin
              underflow <= 1'b1;
              state     <= ST_HALT;
            end else if (!dur_ok) begin
              dur_err <= 1'b1;
              state   <= ST_HALT;
            end else if (op == OP_SYNC) begin
              sync_cnt <= dur_cyc - 1'b1;
              state    <= ST_SYNC;
            end else begin
              cnt   <= dur_cyc - 1'b1;
              state <= ST_RUN;
            end
          end
        end
        ST_SYNC: begin
          if (release_all) begin
            cnt   <= sync_cnt;
            state <= ST_RUN;
          end
        end
        default: begin
          if (clr_err) begin
            underflow <= 1'b0;
            dur_err   <= 1'b0;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign sync_wait = (state == ST_SYNC);

  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow && !clr_err) |=> underflow);

  // R7
  halted_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow || dur_err) |-> !cmd_pop);

  // R6
  offsets_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_strobe |-> ($stable(ofs0) && $stable(ofs1)));

  // R9
  sync_no_apply_chk: assert property (@(posedge clk) disable iff (rst)
    sync_wait |=> !upd_strobe);

  // R2
  no_early_pop_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RUN) && (cnt != '0)) |-> !cmd_pop);
endmodule

// File: tb/rt_cmd_exec_test.sv
module rt_cmd_exec_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic clr_err = 1'b0;
  logic [3:1] pa = '0;
  logic [3:0] en = 4'b0001;
  logic cmd_pop, sync_wait, upd_strobe, play_strobe, underflow, dur_err;
  logic [15:0] ofs0, ofs1;

  int q_op [64];
  int q_dur[64];
  int q_o0 [64];
  int q_o1 [64];
  int q_wr = 0;
  int q_rd = 0;

  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_dur, cmd_o0, cmd_o1;

  assign cmd_valid = (q_rd < q_wr);
  assign cmd_op    = cmd_valid ? 2'(q_op[q_rd])   : 2'd0;
  assign cmd_dur   = cmd_valid ? 16'(q_dur[q_rd]) : 16'd0;
  assign cmd_o0    = cmd_valid ? 16'(q_o0[q_rd])  : 16'd0;
  assign cmd_o1    = cmd_valid ? 16'(q_o1[q_rd])  : 16'd0;

  always #5 clk = ~clk;

  rt_cmd_exec uut (
    .clk(clk), .rst(rst), .start(start), .clr_err(clr_err),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dur(cmd_dur),
    .cmd_ofs0(cmd_o0), .cmd_ofs1(cmd_o1), .cmd_pop(cmd_pop),
    .peer_arrive({pa, sync_wait}), .sync_enable(en), .sync_wait(sync_wait),
    .ofs0(ofs0), .ofs1(ofs1), .upd_strobe(upd_strobe), .play_strobe(play_strobe),
    .underflow(underflow), .dur_err(dur_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model: 0 idle, 1 counting, 2 barrier, 3 halted
  int m_st = 0, m_left = 0, m_sync = 0;
  int m_o0 = 0, m_o1 = 0, m_upd = 0, m_play = 0, m_uf = 0, m_de = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(int op, int dur, int o0, int o1);
    q_op[q_wr] = op; q_dur[q_wr] = dur; q_o0[q_wr] = o0; q_o1[q_wr] = o1;
    q_wr++;
  endtask

  task automatic cmp_outputs();
    chk("R6 ofs0", int'($signed(ofs0)), m_o0);
    chk("R6 ofs1", int'($signed(ofs1)), m_o1);
    chk("R3 upd_strobe", int'(upd_strobe), m_upd);
    chk("R4 play_strobe", int'(play_strobe), m_play);
    chk("R7 underflow", int'(underflow), m_uf);
    chk("R8 dur_err", int'(dur_err), m_de);
    chk("R9 sync_wait", int'(sync_wait), (m_st == 2) ? 1 : 0);
  endtask

  // one clock cycle: inputs already set after the previous falling edge
  task automatic step();
    int n_st, n_left, n_sync, n_o0, n_o1, n_upd, n_play, n_uf, n_de;
    bit due, pop, rel;
    #1;
    n_st = m_st; n_left = m_left; n_sync = m_sync; n_o0 = m_o0; n_o1 = m_o1;
    n_upd = 0; n_play = 0; n_uf = m_uf; n_de = m_de;
    due = (m_st == 0 && start) || (m_st == 1 && m_left == 1);
    pop = due && cmd_valid;
    chk("R2 cmd_pop", int'(cmd_pop), int'(pop));
    if (m_st == 1 && m_left > 1) n_left = m_left - 1;
    else if (due) begin
      if (!cmd_valid) begin n_uf = 1; n_st = 3; end
      else if (q_dur[q_rd] < 4 || (q_dur[q_rd] % 4) != 0) begin n_de = 1; n_st = 3; end
      else if (q_op[q_rd] == 3) begin n_sync = q_dur[q_rd] / 4; n_st = 2; end
      else begin
        n_left = q_dur[q_rd] / 4; n_st = 1;
        if (q_op[q_rd] <= 1) begin
          n_o0 = q_o0[q_rd]; n_o1 = q_o1[q_rd]; n_upd = 1;
          n_play = (q_op[q_rd] == 1) ? 1 : 0;
        end
      end
    end
    if (m_st == 2) begin
      rel = 1;
      for (int i = 1; i < 4; i++) if (en[i] && !pa[i]) rel = 0;
      if (rel) begin n_left = m_sync; n_st = 1; end
    end
    if (m_st == 3 && clr_err) begin n_uf = 0; n_de = 0; n_st = 0; end
    @(posedge clk);
    @(negedge clk);
    if (pop) q_rd++;
    m_st = n_st; m_left = n_left; m_sync = n_sync; m_o0 = n_o0; m_o1 = n_o1;
    m_upd = n_upd; m_play = n_play; m_uf = n_uf; m_de = n_de;
    cmp_outputs();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic kick();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic clear();
    clr_err = 1'b1; step(); clr_err = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 ofs0", int'(ofs0), 0);
    chk("R1 ofs1", int'(ofs1), 0);
    chk("R1 strobes", int'(upd_strobe | play_strobe), 0);
    chk("R1 flags", int'(underflow | dur_err), 0);
    chk("R1 sync_wait", int'(sync_wait), 0);
    chk("R1 cmd_pop", int'(cmd_pop), 0);
    steps(2);

    // back-to-back mix, then starvation
    push(0, 8, 100, -200);
    push(1, 4, 5, 6);
    push(2, 12, 999, 999);
    push(0, 4, -32768, 32767);
    push(1, 4, 11, -11);
    kick();
    steps(12);
    chk("R7 underflow after drain", int'(underflow), 1);

    // refill while halted: no pop; then clear and restart
    push(2, 4, 7, 7);
    push(2, 8, 8, 8);
    steps(4);
    chk("R7 halted keeps queue", q_wr - q_rd, 2);
    clear();
    steps(2);
    kick();
    steps(2);
    chk("R5 wait keeps ofs0", int'($signed(ofs0)), 11);
    chk("R5 wait no strobe", int'(upd_strobe), 0);
    steps(3);
    clear();

    // barrier with staggered arrivals and a disabled member
    en = 4'b0111;
    push(3, 8, 1234, 1234);
    push(0, 4, 1, 2);
    kick();
    steps(4);
    chk("R9 waiting at barrier", int'(sync_wait), 1);
    pa[1] = 1'b1;
    steps(3);
    pa[2] = 1'b1;
    step();
    chk("R10 released with disabled peer absent", int'(sync_wait), 0);
    steps(5);
    pa = '0;
    steps(2);
    clear();

    // only self enabled: immediate release
    en = 4'b0001;
    push(3, 4, 50, 50);
    push(1, 8, 9, 9);
    kick();
    steps(6);
    clear();

    // illegal durations
    push(0, 6, 3, 3);
    kick();
    steps(2);
    chk("R8 not multiple of 4", int'(dur_err), 1);
    clear();
    push(1, 0, 4, 4);
    kick();
    steps(2);
    chk("R8 zero duration", int'(dur_err), 1);
    clear();
    push(0, 2, 4, 4);
    kick();
    steps(2);
    clear();
    steps(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule